// File: doc/BRIEF.md
# MDIO Management Controller

This block is a register-mapped master for the two-wire PHY management bus. It runs Clause 22 read and write frames. Software sets a clock divisor in the control register. It then writes one command word into the data register. That command word holds the opcode, the PHY address, the register address and, for a write, the 16-bit value. The block derives the management clock (MDC) from the system clock, shifts the frame out, and keeps a busy flag set for the whole frame. On a read it takes the PHY's answer into the low half of the data register.

The bidirectional data line is handled through separate out, output-enable and in signals, so the pad or tri-state buffer stays outside the block. Two pin groups exist, internal and external. A control bit picks the group that carries the frame. The other group stays quiet.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control register reads 0x0000001A (divisor 26, busy 0, external select 0), and both MDC pins and both output enables are low.
- R2: The control register (select 0) holds the divisor in bits 6:0 and the external-group select in bit 9, both read/write. Bit 8 shows busy and cannot be written. All other bits read 0.
- R3: The data register (select 1) takes a command with the opcode in bits 29:28 (01 write, 10 read), the PHY address in 27:23, the register address in 22:18 and write data in 15:0. Writing a valid command while idle starts a frame, and busy reads 1 from the following clock cycle.
- R4: The MDC period is the divisor in system clocks, and a divisor below 2 counts as 2. Each period starts with ceil(P/2) low cycles and ends with floor(P/2) high cycles. MDC stays low while idle.
- R5: A frame is 64 bits, sent first bit first: 32 ones, 01, the opcode, the PHY address, the register address, the turnaround 10 on writes, then 16 data bits MSB first. Each bit starts with an MDC low phase and holds for one MDC period.
- R6: On a read the output enable is high for bits 0 to 45 and low for bits 46 to 63. MDIO is sampled on each MDC rising edge of bits 48 to 63, MSB first.
- R7: Busy stays high for exactly 64 × P system clock cycles per frame and then clears.
- R8: When a frame has ended, data register bits 31:16 equal bits 31:16 of the command that started it. Bits 15:0 hold the value read on a read, or the written value on a write.
- R9: A data register write while busy is set is ignored. The running frame, its timing and the register contents are unchanged, and no second frame follows.
- R10: A command with opcode 00 or 11 starts no frame. Busy stays 0 and the data register is unchanged.
- R11: With bit 9 set, the frame appears on the external group and MDIO input is taken from the external group. The internal MDC and output enable stay low, and the reverse holds with bit 9 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 control, 1 data |
| reg_wdata | input | 32 | Write data |
| reg_rd_sel | input | 1 | Read target: 0 control, 1 data |
| reg_rdata | output | 32 | Read data, combinational from reg_rd_sel |
| int_mdc | output | 1 | Internal group MDC |
| int_mdio_o | output | 1 | Internal group MDIO out value |
| int_mdio_oe | output | 1 | Internal group MDIO output enable |
| int_mdio_i | input | 1 | Internal group MDIO input |
| ext_mdc | output | 1 | External group MDC |
| ext_mdio_o | output | 1 | External group MDIO out value |
| ext_mdio_oe | output | 1 | External group MDIO output enable |
| ext_mdio_i | input | 1 | External group MDIO input |

## Verification
Busy is due one clock after the edge that takes a command, so the bench reads it at the next falling clock edge. It then counts falling edges with busy high, expecting 64 × P, and counts the MDC high samples, expecting 64 × floor(P/2). A PHY responder captures the line and the output enable on every MDC rising edge. It drives read data after each MDC falling edge, so every captured bit is compared at the edge where the master's behaviour defines it. The scoreboard compares each frame at the first falling clock edge after busy drops. The data register is read only after that point, when its final value is due.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int DIV_W      = 7;
  localparam int FRAME_LEN  = 64;
  localparam int PRE_LEN    = 32;
  localparam int RD_RELEASE = 46;
  localparam int RD_DATA0   = 48;
  localparam int IDX_W      = $clog2(FRAME_LEN);

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdm_op_e;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mdm_cmd_t;

  function automatic logic op_is_valid(input logic [1:0] op);
    return (op == OP_WRITE) || (op == OP_READ);
  endfunction

  // divisor values below two would make no usable clock
  function automatic logic [DIV_W-1:0] period_of(input logic [DIV_W-1:0] div);
    return (div < DIV_W'(2)) ? DIV_W'(2) : div;
  endfunction

  // low phase is the rounded-up half of the period
  function automatic logic [DIV_W-1:0] low_phase(input logic [DIV_W-1:0] per);
    return (per >> 1) + DIV_W'(per[0]);
  endfunction

  function automatic logic [FRAME_LEN-1:0] frame_of(input mdm_cmd_t c);
    return {{PRE_LEN{1'b1}}, 2'b01, c.op, c.phy, c.regad, 2'b10, c.wdata};
  endfunction
endpackage

// File: rtl/mdm_tick.sv
module mdm_tick
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] period,
  input  logic [DIV_W-1:0] low_len,
  output logic             mdc,
  output logic             rise_ev,
  output logic             end_ev
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || cnt == period - 1'b1) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign mdc     = run && (cnt >= low_len);
  assign rise_ev = run && (cnt == low_len - 1'b1);
  assign end_ev  = run && (cnt == period - 1'b1);

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < period));

  p_mdc_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(rise_ev));
endmodule

// File: rtl/mdm_frame.sv
module mdm_frame
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  mdm_cmd_t         cmd_in,
  input  logic [DIV_W-1:0] per_in,
  input  logic             rise_ev,
  input  logic             end_ev,
  input  logic             mdio_in,
  output logic             busy,
  output logic [DIV_W-1:0] per_q,
  output logic [IDX_W-1:0] bit_idx,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [15:0]      result
);
  logic [FRAME_LEN-1:0] frame_q;
  logic                 is_rd;
  logic [15:0]          rd_shift;
  logic                 last_bit;
  logic                 in_data;

  assign last_bit = (bit_idx == IDX_W'(FRAME_LEN - 1));
  assign in_data  = (bit_idx >= IDX_W'(RD_DATA0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      per_q    <= DIV_W'(2);
      bit_idx  <= '0;
      frame_q  <= '0;
      is_rd    <= 1'b0;
      rd_shift <= '0;
      result   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        bit_idx <= '0;
        frame_q <= frame_of(cmd_in);
        is_rd   <= (cmd_in.op == OP_READ);
        per_q   <= per_in;
        result  <= cmd_in.wdata;
      end
    end else begin
      if (rise_ev && is_rd && in_data) begin
        rd_shift <= {rd_shift[14:0], mdio_in};
      end
      if (end_ev) begin
        if (last_bit) begin
          busy <= 1'b0;
          if (is_rd) result <= rd_shift;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end

  assign mdio_o  = frame_q[IDX_W'(FRAME_LEN - 1) - bit_idx];
  assign mdio_oe = busy && (!is_rd || (bit_idx < IDX_W'(RD_RELEASE)));

  p_bit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !end_ev) |=> $stable(bit_idx));

  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(end_ev) && $past(last_bit)));

  p_frame_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(frame_q));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdm_pkg::*;
#(
  parameter logic [DIV_W-1:0] RESET_DIV = 7'h1A,
  parameter int BUSY_BIT = 8,
  parameter int EXT_BIT  = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_wr_sel,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rd_sel,
  output logic [31:0] reg_rdata,
  output logic        int_mdc,
  output logic        int_mdio_o,
  output logic        int_mdio_oe,
  input  logic        int_mdio_i,
  output logic        ext_mdc,
  output logic        ext_mdio_o,
  output logic        ext_mdio_oe,
  input  logic        ext_mdio_i
);
  logic [DIV_W-1:0] div_q;
  logic             ext_q;
  logic [15:0]      cmd_hi_q;
  mdm_cmd_t         cmd_w;
  logic             start_ev;
  logic             busy;
  logic [DIV_W-1:0] per_q;
  logic [DIV_W-1:0] low_len;
  logic [IDX_W-1:0] bit_idx;
  logic             mdc, rise_ev, end_ev;
  logic             mdio_o, mdio_oe, mdio_in;
  logic [15:0]      result;

  assign cmd_w = '{op: reg_wdata[29:28], phy: reg_wdata[27:23],
                   regad: reg_wdata[22:18], wdata: reg_wdata[15:0]};

  assign start_ev = reg_wr && reg_wr_sel && !busy && op_is_valid(cmd_w.op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= RESET_DIV;
      ext_q    <= 1'b0;
      cmd_hi_q <= '0;
    end else begin
      if (reg_wr && !reg_wr_sel) begin
        div_q <= reg_wdata[DIV_W-1:0];
        ext_q <= reg_wdata[EXT_BIT];
      end
      if (start_ev) cmd_hi_q <= reg_wdata[31:16];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd_sel) begin
      reg_rdata = {cmd_hi_q, result};
    end else begin
      reg_rdata[DIV_W-1:0] = div_q;
      reg_rdata[BUSY_BIT]  = busy;
      reg_rdata[EXT_BIT]   = ext_q;
    end
  end

  assign low_len = low_phase(per_q);

  mdm_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_ev),
    .cmd_in  (cmd_w),
    .per_in  (period_of(div_q)),
    .rise_ev (rise_ev),
    .end_ev  (end_ev),
    .mdio_in (mdio_in),
    .busy    (busy),
    .per_q   (per_q),
    .bit_idx (bit_idx),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .result  (result)
  );

  mdm_tick u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .period  (per_q),
    .low_len (low_len),
    .mdc     (mdc),
    .rise_ev (rise_ev),
    .end_ev  (end_ev)
  );

  // pin group steering
  assign int_mdc     = !ext_q && mdc;
  assign int_mdio_oe = !ext_q && mdio_oe;
  assign int_mdio_o  = mdio_o;
  assign ext_mdc     = ext_q && mdc;
  assign ext_mdio_oe = ext_q && mdio_oe;
  assign ext_mdio_o  = mdio_o;
  assign mdio_in     = ext_q ? ext_mdio_i : int_mdio_i;

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (busy && bit_idx == '0));

  p_bad_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wr_sel && !busy && !op_is_valid(cmd_w.op)) |=> !busy);

  p_quiet_group_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q |-> (!int_mdc && !int_mdio_oe));
endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_wr_sel = 1'b0, reg_rd_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        int_mdc, int_mdio_o, int_mdio_oe, int_mdio_i;
  logic        ext_mdc, ext_mdio_o, ext_mdio_oe, ext_mdio_i;

  int total = 0;
  int bad   = 0;

  // responder state
  logic        use_ext = 1'b0;
  logic        phy_en = 1'b0, phy_v = 1'b1;
  logic        rsp_rd = 1'b0;
  logic [15:0] rsp_val = '0;
  logic [63:0] cap_frame, cap_oe;
  int          rises = 0, falls = 0, int_rises = 0;

  wire sel_mdc  = use_ext ? ext_mdc     : int_mdc;
  wire sel_o    = use_ext ? ext_mdio_o  : int_mdio_o;
  wire sel_oe   = use_ext ? ext_mdio_oe : int_mdio_oe;
  wire line     = sel_oe ? sel_o : (phy_en ? phy_v : 1'b1);
  assign int_mdio_i = use_ext ? 1'b0 : line;
  assign ext_mdio_i = use_ext ? line : 1'b0;

  mdio_mgmt_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wr_sel(reg_wr_sel),
    .reg_wdata(reg_wdata), .reg_rd_sel(reg_rd_sel), .reg_rdata(reg_rdata),
    .int_mdc(int_mdc), .int_mdio_o(int_mdio_o), .int_mdio_oe(int_mdio_oe),
    .int_mdio_i(int_mdio_i), .ext_mdc(ext_mdc), .ext_mdio_o(ext_mdio_o),
    .ext_mdio_oe(ext_mdio_oe), .ext_mdio_i(ext_mdio_i)
  );

  always @(posedge sel_mdc) begin
    if (rises < 64) begin
      cap_frame[63 - rises] = line;
      cap_oe[63 - rises]    = sel_oe;
    end
    rises = rises + 1;
  end

  always @(negedge sel_mdc) begin
    falls = falls + 1;
    if (rsp_rd && falls == 47) begin
      phy_en = 1'b1; phy_v = 1'b0;
    end else if (rsp_rd && falls >= 48 && falls <= 63) begin
      phy_en = 1'b1; phy_v = rsp_val[63 - falls];
    end else begin
      phy_en = 1'b0;
    end
  end

  always @(posedge int_mdc) int_rises = int_rises + 1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {
    logic [63:0] frame;
    logic [63:0] oe;
    int          cycles;
    int          high;
  } exp_t;
  exp_t q[$];

  wire busy_obs = !reg_rd_sel && reg_rdata[8];
  int  cyc = 0, hi = 0;
  bit  in_f = 0;

  always @(negedge clk) begin
    if (busy_obs) begin
      in_f = 1; cyc = cyc + 1;
      if (sel_mdc) hi = hi + 1;
    end else if (in_f) begin
      in_f = 0;
      if (q.size() == 0) begin
        check("R9 unexpected frame", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check("R5 frame bits", cap_frame, e.frame);
        check("R6 output enable pattern", cap_oe, e.oe);
        check("R7 busy cycles", 64'(cyc), 64'(e.cycles));
        check("R4 mdc high cycles", 64'(hi), 64'(e.high));
        check("R4 mdc rise count", 64'(rises), 64'd64);
      end
      cyc = 0; hi = 0;
    end
  end

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wr_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [31:0] v);
    #1;
    reg_rd_sel = sel;
    #0.5;
    v = reg_rdata;
    reg_rd_sel = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                     input logic [4:0] ra, input logic [15:0] d);
    return {2'b00, op, phy, ra, 2'b00, d};
  endfunction

  task automatic run_cmd(input logic [31:0] cmd, input int per, input logic [15:0] val);
    exp_t e;
    logic rd;
    logic [31:0] v;
    rd = (cmd[29:28] == 2'b10);
    e.frame  = {32'hFFFF_FFFF, 2'b01, cmd[29:28], cmd[27:23], cmd[22:18], 2'b10,
                rd ? val : cmd[15:0]};
    e.oe     = rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
    e.cycles = 64 * per;
    e.high   = 64 * (per / 2);
    q.push_back(e);
    rsp_rd = rd; rsp_val = val; rises = 0; falls = 0;
    reg_write(1'b1, cmd);
    reg_read(1'b0, v);
    check("R3 busy after start", 64'(v[8]), 64'd1);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    do begin
      @(negedge clk);
      reg_read(1'b0, v);
    end while (v[8]);
    @(negedge clk);
  endtask

  task automatic check_data(input string tag, input logic [31:0] cmd, input logic [15:0] lo);
    logic [31:0] v;
    reg_read(1'b1, v);
    check(tag, 64'(v), 64'({cmd[31:16], lo}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad = bad + 1; total = total + 1;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, ca, cb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(1'b0, v);
    check("R1 control reset value", 64'(v), 64'h1A);
    check("R1 pins quiet", 64'({int_mdc, int_mdio_oe, ext_mdc, ext_mdio_oe}), 64'd0);

    // R2 control register fields, busy not writable
    reg_write(1'b0, 32'hFFFF_FFFF);
    reg_read(1'b0, v);
    check("R2 control readback", 64'(v), 64'h27F);
    reg_write(1'b0, 32'h0000_0003);
    reg_read(1'b0, v);
    check("R2 control readback div3", 64'(v), 64'h003);

    // R5 R7 write frame, odd period
    ca = mk(2'b01, 5'h11, 5'h0A, 16'hA5C3);
    run_cmd(ca, 3, 16'h0);
    wait_idle();
    check_data("R8 data after write", ca, 16'hA5C3);

    // R4 divisor 0 counts as 2; R6 read
    reg_write(1'b0, 32'h0000_0000);
    ca = mk(2'b10, 5'h03, 5'h1F, 16'h0000);
    run_cmd(ca, 2, 16'h8E71);
    wait_idle();
    check_data("R8 R6 data after read", ca, 16'h8E71);

    // R11 external group, read with period 5
    reg_write(1'b0, 32'h0000_0205);
    use_ext = 1'b1; int_rises = 0;
    ca = mk(2'b10, 5'h1E, 5'h01, 16'h5555);
    run_cmd(ca, 5, 16'h1234);
    wait_idle();
    check_data("R11 read via external input", ca, 16'h1234);
    check("R11 internal mdc idle", 64'(int_rises), 64'd0);
    reg_write(1'b0, 32'h0000_0004);
    use_ext = 1'b0;

    // R9 write while busy
    ca = mk(2'b01, 5'h07, 5'h12, 16'h0F0F);
    cb = mk(2'b10, 5'h19, 5'h05, 16'hFFFF);
    run_cmd(ca, 4, 16'h0);
    repeat (20) @(negedge clk);
    reg_write(1'b1, cb);
    wait_idle();
    check_data("R9 data keeps first command", ca, 16'h0F0F);
    repeat (10) @(negedge clk);
    reg_read(1'b0, v);
    check("R9 no second frame", 64'(v[8]), 64'd0);

    // R10 invalid opcodes
    reg_write(1'b1, mk(2'b00, 5'h01, 5'h01, 16'h1111));
    reg_read(1'b0, v);
    check("R10 op 00 no busy", 64'(v[8]), 64'd0);
    reg_write(1'b1, mk(2'b11, 5'h01, 5'h01, 16'h2222));
    repeat (5) @(negedge clk);
    reg_read(1'b0, v);
    check("R10 op 11 no busy", 64'(v[8]), 64'd0);
    check("R10 pins quiet", 64'({int_mdc, int_mdio_oe}), 64'd0);
    check_data("R10 data unchanged", ca, 16'h0F0F);

    // R4 divisor 1 counts as 2
    reg_write(1'b0, 32'h0000_0001);
    ca = mk(2'b01, 5'h00, 5'h00, 16'h8001);
    run_cmd(ca, 2, 16'h0);
    wait_idle();
    check_data("R8 data after divisor-1 write", ca, 16'h8001);

    check("R7 scoreboard drained", 64'(q.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule